// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit executes the conditional-select instruction class of a 64-bit core that also runs a 32-bit mode. For each accepted instruction it takes the 32-bit instruction word, the two source operand values fetched by the register read stage and the four condition flags (negative, zero, carry, overflow). If the encoded condition holds on the flags, the result is the first source. Otherwise it is the second source passed through one of four transforms: a plain move, an increment, a bitwise inversion or a two's-complement negation. Two separate instruction bits pick the transform.

Reserved encodings are reported as undefined, and such instructions write nothing. In 32-bit mode the operands are used through their low half, and the result is zero-extended to the full width. A destination index of 31 discards the result. A source index of 31 reads as zero, whatever value the read port supplied. The result, the write enable, the destination index and the undefined flag are registered and appear one clock after the input strobe, together with an output-valid pulse.

Top module: `csel_unit`

## Requirements
- R1: After reset, `out_valid`, `wr_en` and `undef` are 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0. `wr_en` and `undef` are 0 whenever `out_valid` is 0.
- R3: An instruction with bit 29 = 1 or bit 11 = 1 gives `undef` = 1, `wr_en` = 0 and `result` = 0.
- R4: When the condition holds, `result` is the first source, taken from `rn_val` (instruction bits [9:5] give its index).
- R5: When the condition fails, `result` comes from the second source (`rm_val`, index in bits [20:16]). With bit 30 = 0 and bit 10 = 0 it is moved unchanged. With bit 30 = 0 and bit 10 = 1 it is incremented. With bit 30 = 1 and bit 10 = 0 it is inverted bit by bit. With both bits set it is negated.
- R6: Condition codes 14 and 15 (bits [15:12]) always select the first source.
- R7: The flags input is `nzcv` = {N,Z,C,V}, with N in bit 3. The codes 0..13 test, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !(C&!Z), N==V, N!=V, !Z&(N==V), !(!Z&(N==V)).
- R8: When bit 31 is 0 (32-bit mode), the operands are used through their low 32 bits, the arithmetic wraps at 32 bits and `result[63:32]` is 0.
- R9: A destination index (bits [4:0]) of 31 gives `wr_en` = 0. All other defined instructions give `wr_en` = 1.
- R10: A source index of 31 reads as zero, whatever the matching operand input holds.
- R11: `wr_idx` equals the destination index of the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| rn_val | input | 64 | Value read for the first source index |
| rm_val | input | 64 | Value read for the second source index |
| nzcv | input | 4 | Condition flags {N,Z,C,V} |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Selected and transformed value |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 5 | Destination register index |
| undef | output | 1 | Reserved encoding detected |

## Verification
All sixteen condition codes are applied against all sixteen flag combinations, with operand values that differ in every transform. A wrong mapping or a swapped polarity therefore shows up as the wrong source being chosen. The four transforms are run in both widths on operands near the wrap points (all ones, the 32-bit boundary and zero), which tells increment apart from negate and shows where a 32-bit carry leaks into the upper half. Reserved bits, index 31 used as destination and as source, idle cycles between strobes, and a long random stream check the write-enable and zero-source rules against the bench's own model.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int IDX_W  = 5;
  localparam int COND_W = 4;

  typedef struct packed {
    logic              wide;
    logic              inv;
    logic              rsv_s;
    logic [7:0]        klass;
    logic [IDX_W-1:0]  src_b;
    logic [COND_W-1:0] cond;
    logic              rsv_hi;
    logic              inc;
    logic [IDX_W-1:0]  src_a;
    logic [IDX_W-1:0]  dst;
  } csel_word_t;

  typedef enum logic [1:0] {
    XF_MOVE = 2'b00,
    XF_INC  = 2'b01,
    XF_NOT  = 2'b10,
    XF_NEG  = 2'b11
  } xform_e;

  // Pairwise base test, odd code flips it (except the always pair)
  function automatic logic cond_eval(input logic [COND_W-1:0] c, input logic [3:0] f);
    logic n, z, cy, v, base;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    return (c[0] && c[3:1] != 3'd7) ? ~base : base;
  endfunction
endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
(
  input  logic [31:0]      insn,
  output logic             wide,
  output xform_e           xf,
  output logic [COND_W-1:0] cond,
  output logic [IDX_W-1:0] src_a,
  output logic [IDX_W-1:0] src_b,
  output logic [IDX_W-1:0] dst,
  output logic             reserved
);
  csel_word_t w;
  assign w        = csel_word_t'(insn);
  assign wide     = w.wide;
  assign xf       = xform_e'({w.inv, w.inc});
  assign cond     = w.cond;
  assign src_a    = w.src_a;
  assign src_b    = w.src_b;
  assign dst      = w.dst;
  assign reserved = w.rsv_s | w.rsv_hi;
endmodule

// File: rtl/csel_cond.sv
module csel_cond
  import csel_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [3:0]        nzcv,
  output logic              holds,
  output logic              always_code
);
  assign holds       = cond_eval(cond, nzcv);
  assign always_code = (cond[COND_W-1:1] == '1);
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
)(
  input  logic             wide,
  input  xform_e           xf,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic [XLEN-1:0]  a_val,
  input  logic [XLEN-1:0]  b_val,
  input  logic             holds,
  input  logic             reserved,
  output logic [XLEN-1:0]  value
);
  localparam int UPPER = XLEN - NARROW;
  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  function automatic logic [XLEN-1:0] apply_xf(input xform_e k, input logic [XLEN-1:0] v);
    logic [XLEN-1:0] t;
    t = k[1] ? ~v : v;
    t = t + {{(XLEN-1){1'b0}}, k[0]};
    return t;
  endfunction

  function automatic logic [XLEN-1:0] fit(input logic w, input logic [XLEN-1:0] v);
    return w ? v : {{UPPER{1'b0}}, v[NARROW-1:0]};
  endfunction

  logic [XLEN-1:0] opa, opb, picked;
  assign opa    = (src_a == ZERO_IDX) ? '0 : a_val;
  assign opb    = (src_b == ZERO_IDX) ? '0 : b_val;
  assign picked = holds ? opa : apply_xf(xf, opb);
  assign value  = reserved ? '0 : fit(wide, picked);
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [XLEN-1:0]  rn_val,
  input  logic [XLEN-1:0]  rm_val,
  input  logic [3:0]       nzcv,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             undef
);
  logic             dec_wide, dec_rsv, cond_true, cond_always;
  xform_e           dec_xf;
  logic [COND_W-1:0] dec_cond;
  logic [IDX_W-1:0] dec_a, dec_b, dec_dst;
  logic [XLEN-1:0]  next_value;
  logic             dst_discard, wide_q;

  csel_decode u_dec (
    .insn(insn), .wide(dec_wide), .xf(dec_xf), .cond(dec_cond),
    .src_a(dec_a), .src_b(dec_b), .dst(dec_dst), .reserved(dec_rsv)
  );

  csel_cond u_cond (
    .cond(dec_cond), .nzcv(nzcv), .holds(cond_true), .always_code(cond_always)
  );

  csel_datapath #(.XLEN(XLEN), .NARROW(NARROW)) u_dp (
    .wide(dec_wide), .xf(dec_xf), .src_a(dec_a), .src_b(dec_b),
    .a_val(rn_val), .b_val(rm_val), .holds(cond_true),
    .reserved(dec_rsv), .value(next_value)
  );

  assign dst_discard = (dec_dst == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      undef     <= 1'b0;
      result    <= '0;
      wr_idx    <= '0;
      wide_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & ~dec_rsv & ~dst_discard;
      undef     <= in_valid & dec_rsv;
      if (in_valid) begin
        result <= next_value;
        wr_idx <= dec_dst;
        wide_q <= dec_wide;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !undef));
  // R3
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef) |-> (!wr_en && result == '0));
  // R6
  always_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_always) |-> cond_true);
  // R8
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (result[XLEN-1:NARROW] == '0));
  // R9
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_idx == '1) |-> !wr_en);
endmodule

// File: tb/sim_csel_unit.sv
module sim_csel_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rn_val = '0, rm_val = '0;
  logic [3:0]  nzcv = '0;
  logic        out_valid, wr_en, undef;
  logic [63:0] result;
  logic [4:0]  wr_idx;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #(PERIOD/2) clk = ~clk;

  csel_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rn_val(rn_val), .rm_val(rm_val), .nzcv(nzcv), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .undef(undef)
  );

  function automatic logic [31:0] mk(input bit sf, input bit op, input bit s,
      input int rm, input int cnd, input int op2, input int rn, input int rd);
    return {sf, op, s, 8'b1101_0100, rm[4:0], cnd[3:0], op2[1:0], rn[4:0], rd[4:0]};
  endfunction

  function automatic bit ref_cond(input int c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy && !z;     9: return !(cy && !z);
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return !(!z && n == v);
      default: return 1;
    endcase
  endfunction

  logic [63:0] e_res;
  bit e_valid, e_wr, e_undef;
  logic [4:0] e_idx;

  task automatic model(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] f, input bit v);
    logic [63:0] x, y, r;
    longint unsigned mask;
    mask = w[31] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    x = (w[9:5] == 5'd31) ? 64'd0 : a;
    y = (w[20:16] == 5'd31) ? 64'd0 : b;
    if (ref_cond(int'(w[15:12]), f)) r = x;
    else if (w[30] && w[10]) r = 64'd0 - y;
    else if (w[30]) r = ~y;
    else if (w[10]) r = y + 64'd1;
    else r = y;
    r = r & mask;
    e_valid = v;
    if (v) begin
      e_undef = w[29] || w[11];
      e_wr    = !e_undef && (w[4:0] != 5'd31);
      e_res   = e_undef ? 64'd0 : r;
      e_idx   = w[4:0];
    end else begin
      e_undef = 0;
      e_wr    = 0;
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] f, input bit v, input string tag);
    @(negedge clk);
    insn = w; rn_val = a; rm_val = b; nzcv = f; in_valid = v;
    model(w, a, b, f, v);
    @(posedge clk);
    #2;
    vectors++;
    if (out_valid !== e_valid || wr_en !== e_wr || undef !== e_undef ||
        (e_valid && (result !== e_res || wr_idx !== e_idx))) begin
      misses++;
      $display("FAIL %s insn=%h: got v=%b wr=%b ud=%b res=%h idx=%0d exp v=%b wr=%b ud=%b res=%h idx=%0d",
               tag, w, out_valid, wr_en, undef, result, wr_idx,
               e_valid, e_wr, e_undef, e_res, e_idx);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [63:0] ops [4];
    ops[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    ops[1] = 64'h0000_0000_FFFF_FFFF;
    ops[2] = 64'h0000_0000_0000_0000;
    ops[3] = 64'h8000_0001_7FFF_FFFE;

    repeat (3) @(posedge clk);
    #2;
    vectors++;
    // R1 reset state
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || undef !== 1'b0) begin
      misses++;
      $display("FAIL R1 reset: got v=%b wr=%b ud=%b exp 0 0 0", out_valid, wr_en, undef);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R7 / R4 / R6: every code against every flag set
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        apply(mk(1, f[0], 0, 3, c, {1'b0, f[1]}, 7, 9), 64'h1234_5678_9ABC_DEF0,
              64'h0FED_CBA9_8765_4321, f[3:0], 1, (c >= 14) ? "R6" : "R7");

    // R5 / R8: transforms on both widths, condition forced false (code 0, Z=0)
    for (int sf = 0; sf < 2; sf++)
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 4; i++)
          apply(mk(sf[0], k[1], 0, 4, 0, {1'b0, k[0]}, 5, 6), 64'hAAAA_5555_AAAA_5555,
                ops[i], 4'b0000, 1, sf == 0 ? "R8" : "R5");

    // R4 / R8: true path in 32-bit mode truncates the first source
    apply(mk(0, 0, 0, 4, 1, 0, 5, 6), 64'hDEAD_BEEF_0123_4567, 64'd0, 4'b0000, 1, "R8");
    apply(mk(1, 0, 0, 4, 1, 0, 5, 6), 64'hDEAD_BEEF_0123_4567, 64'd0, 4'b0000, 1, "R4");

    // R3 reserved encodings
    apply(mk(1, 0, 1, 4, 14, 0, 5, 6), 64'h55, 64'h66, 4'b0000, 1, "R3");
    apply(mk(1, 1, 0, 4, 14, 2, 5, 6), 64'h55, 64'h66, 4'b0000, 1, "R3");
    apply(mk(0, 1, 1, 4, 0, 3, 5, 31), 64'h55, 64'h66, 4'b0000, 1, "R3");

    // R9 destination 31, R11 destination index
    apply(mk(1, 0, 0, 4, 14, 0, 5, 31), 64'h77, 64'h88, 4'b0000, 1, "R9");
    apply(mk(1, 0, 0, 4, 14, 0, 5, 0), 64'h77, 64'h88, 4'b0000, 1, "R11");
    apply(mk(1, 0, 0, 4, 14, 0, 5, 30), 64'h77, 64'h88, 4'b0000, 1, "R11");

    // R10 source index 31 reads zero on both paths
    apply(mk(1, 0, 0, 4, 15, 0, 31, 2), 64'hFFFF, 64'h1, 4'b0000, 1, "R10");
    apply(mk(1, 1, 0, 31, 0, 1, 5, 2), 64'hFFFF, 64'h1234, 4'b0000, 1, "R10");
    apply(mk(0, 0, 0, 31, 0, 1, 5, 2), 64'hFFFF, 64'h1234, 4'b0000, 1, "R10");

    // R2 idle cycles and back-to-back strobes
    apply(mk(1, 0, 0, 4, 14, 0, 5, 6), 64'h99, 64'h0, 4'b0000, 0, "R2");
    apply(mk(1, 0, 0, 4, 14, 0, 5, 6), 64'h99, 64'h0, 4'b0000, 0, "R2");
    apply(mk(1, 0, 0, 4, 14, 0, 5, 6), 64'h99, 64'h0, 4'b0000, 1, "R2");
    apply(mk(1, 0, 1, 4, 14, 0, 5, 6), 64'h99, 64'h0, 4'b0000, 0, "R2");

    // Random stream over all rules (R3 R5 R7 R9 R10)
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] w;
      w = $urandom;
      w[28:21] = 8'b1101_0100;
      if ((n % 4) != 0) begin w[29] = 0; w[11] = 0; end
      apply(w, {$urandom, $urandom}, {$urandom, $urandom}, 4'($urandom),
            (n % 7) != 0, "R5-rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule